// File: doc/BRIEF.md
# Four-Bank SDRAM Command Legality Checker

This block sits beside the command bus of a four-bank single-data-rate SDRAM and judges every command issued on it. It decodes the chip-select, row-strobe, column-strobe and write-enable lines. It keeps a timed model of each bank: idle, opening, open, bursting, bursting with auto-precharge, or closing. A command that the target bank cannot accept in its present state lowers a legal flag and latches an error code that names the command and the bank. A command that can be accepted is applied to the model, so the check that follows it sees the updated bank states.

The model works across banks. A read or write to one bank cuts short a burst that is running in any other bank. If that burst carried auto-precharge, the other bank goes straight into its closing interval. A precharge with the all-banks address bit set is judged against every bank at once. The row-to-column delay, the precharge time, the burst length and the wake-up delay after the clock-enable line comes back high are run-time inputs counted in clock cycles.

Top module: `sdram_cmd_guard`

## Requirements
- R1: With `cs_n`=1 the cycle is an inhibit. With `cs_n`=0 the pins {`ras_n`,`cas_n`,`we_n`} decode as 011 activate, 101 read, 100 write, 010 precharge and 111 no-operation. Any other pattern, such as 001 refresh, is outside the model. Inhibit, no-operation and out-of-model patterns are always legal and do not change any bank state.
- R2: `bank_state_o[3*i+2:3*i]` holds the state of bank i, coded 0 idle, 1 opening, 2 open, 3 read, 4 write, 5 read with auto-precharge, 6 write with auto-precharge, 7 closing. An activate is legal only to an idle bank. An activate at cycle t shows 1 from t+1 and 2 from t+`cfg_trcd`. When `cfg_trcd` is 1 or less, the bank shows 2 at t+1.
- R3: A read or write is legal only to a bank in state 2, 3 or 4. Sent to a bank in any other state, it is illegal.
- R4: A read (write) with `a10`=0 at cycle t puts the target bank in state 3 (4) from t+1 and returns it to 2 at t+`cfg_burst`. When `cfg_burst` is 1 or less, the bank shows 2 at t+1. A read or write to the bank's own running burst restarts it.
- R5: A read (write) with `a10`=1 at cycle t puts the bank in state 5 (6) until t+`cfg_burst`+`cfg_trp`, when it shows 0. Read, write, precharge and activate are all illegal to a bank in state 5 or 6.
- R6: A precharge with `a10`=0 is illegal to a bank in state 1, 5 or 6. It is legal, with no effect, to a bank in state 0 or 7. To a bank in state 2, 3 or 4 at cycle t, it gives state 7 from t+1 and 0 from t+`cfg_trp`.
- R7: A precharge with `a10`=1 addresses every bank. It is illegal if any bank is in state 1, 5 or 6. Otherwise every bank in state 2, 3 or 4 closes as in R6.
- R8: An accepted read or write to bank m returns any other bank in state 3 or 4 to state 2 at once. Any other bank in state 5 or 6 goes to state 7 and reaches 0 `cfg_trp` cycles after the command. At most one bank is ever in states 3 to 6.
- R9: `legal_o` and `err_code_o` reflect the command of the previous cycle. An illegal command drives `legal_o` to 0 and loads `err_code_o` = {code, `ba`}, where code is 1 activate, 2 read, 3 write, 4 single precharge, 5 all-bank precharge. The code holds until the next illegal command. An illegal command leaves every bank state unchanged apart from its timers running.
- R10: While `cke` is 0, all bank states and timers freeze, commands are ignored and `legal_o` reads 1. The cycle in which `cke` returns high, and the `cfg_txsr` cycles after it, are also unchecked: commands are ignored but timers run.
- R11: Reset gives `legal_o`=1, `err_code_o`=0 and every bank idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock-enable line of the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (2) | Bank address |
| a10 | input | 1 | Auto-precharge / all-banks select |
| cfg_trcd | input | CNT_W (4) | Row-to-column delay in cycles |
| cfg_trp | input | CNT_W (4) | Precharge time in cycles |
| cfg_burst | input | CNT_W (4) | Burst length in cycles |
| cfg_txsr | input | XSR_W (8) | Unchecked cycles after `cke` returns high |
| legal_o | output | 1 | Previous command was legal |
| err_code_o | output | 3+BA_W (5) | Command code and bank of last illegal command |
| bank_state_o | output | 3*NUM_BANKS (12) | Packed per-bank state |

## Verification
The bench builds the block with its default parameters: four banks, 4-bit interval counts and an 8-bit wake-up count. The main table drives it with all three intervals set to 2. That exercises the multi-cycle paths of every timer, a burst cut short in another bank, all-bank precharge against an opening bank, and the self-expiry of auto-precharge. Directed runs set the intervals to 1, which reaches the branch where the timed state is skipped entirely. A further run sets `cfg_trcd`=3 and `cfg_txsr`=2, which holds a bank mid-interval while `cke` is low and shows the unchecked window after `cke` returns high.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_RD    = 3'd2,
        CMD_WR    = 3'd3,
        CMD_PRE   = 3'd4,
        CMD_OTHER = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE    = 3'd0,
        BK_OPENING = 3'd1,
        BK_OPEN    = 3'd2,
        BK_RD      = 3'd3,
        BK_WR      = 3'd4,
        BK_RD_AP   = 3'd5,
        BK_WR_AP   = 3'd6,
        BK_CLOSING = 3'd7
    } bank_e;

    localparam logic [2:0] CODE_PRE_ALL = 3'd5;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_guard_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd_o
);

    always_comb begin
        if (cs_n) begin
            cmd_o = CMD_NONE;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd_o = CMD_ACT;
                3'b101:  cmd_o = CMD_RD;
                3'b100:  cmd_o = CMD_WR;
                3'b010:  cmd_o = CMD_PRE;
                3'b111:  cmd_o = CMD_NONE;
                default: cmd_o = CMD_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
    import sdram_guard_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             accept,
    input  logic             hit,
    input  cmd_e             cmd,
    input  logic             a10,
    input  logic [CNT_W-1:0] trcd,
    input  logic [CNT_W-1:0] trp,
    input  logic [CNT_W-1:0] burst,
    output bank_e            state_o,
    output logic             ok_o
);

    localparam int TMR_W = CNT_W + 1;

    typedef struct packed {
        bank_e            st;
        logic [TMR_W-1:0] cnt;
    } trk_t;

    trk_t trk_d, trk_q;

    // Enter a timed state for n cycles, or go straight on when n is 0 or 1.
    function automatic trk_t arm(bank_e timed, bank_e after, logic [TMR_W-1:0] n);
        trk_t r;
        if (n <= TMR_W'(1)) begin
            r.st  = after;
            r.cnt = '0;
        end else begin
            r.st  = timed;
            r.cnt = n - TMR_W'(1);
        end
        return r;
    endfunction

    logic [TMR_W-1:0] n_rcd, n_rp, n_bl, n_ap;
    logic             in_burst, row_open;

    assign n_rcd    = TMR_W'(trcd);
    assign n_rp     = TMR_W'(trp);
    assign n_bl     = TMR_W'(burst);
    assign n_ap     = TMR_W'(burst) + TMR_W'(trp);
    assign in_burst = (trk_q.st == BK_RD) || (trk_q.st == BK_WR);
    assign row_open = in_burst || (trk_q.st == BK_OPEN);

    always_comb begin
        case (cmd)
            CMD_ACT: ok_o = (trk_q.st == BK_IDLE);
            CMD_RD,
            CMD_WR:  ok_o = row_open;
            CMD_PRE: ok_o = !((trk_q.st == BK_OPENING) || (trk_q.st == BK_RD_AP) ||
                              (trk_q.st == BK_WR_AP));
            default: ok_o = 1'b1;
        endcase
    end

    always_comb begin
        trk_d = trk_q;
        if (run) begin
            // interval expiry
            if (trk_q.cnt > TMR_W'(1)) begin
                trk_d.cnt = trk_q.cnt - TMR_W'(1);
            end else begin
                trk_d.cnt = '0;
                case (trk_q.st)
                    BK_OPENING, BK_RD, BK_WR:        trk_d.st = BK_OPEN;
                    BK_RD_AP, BK_WR_AP, BK_CLOSING:  trk_d.st = BK_IDLE;
                    default:                         trk_d.st = trk_q.st;
                endcase
            end
            // accepted command
            if (accept) begin
                if (hit) begin
                    case (cmd)
                        CMD_ACT: trk_d = arm(BK_OPENING, BK_OPEN, n_rcd);
                        CMD_RD:  trk_d = a10 ? arm(BK_RD_AP, BK_IDLE, n_ap)
                                             : arm(BK_RD, BK_OPEN, n_bl);
                        CMD_WR:  trk_d = a10 ? arm(BK_WR_AP, BK_IDLE, n_ap)
                                             : arm(BK_WR, BK_OPEN, n_bl);
                        CMD_PRE: if (row_open) trk_d = arm(BK_CLOSING, BK_IDLE, n_rp);
                        default: ;
                    endcase
                end else if ((cmd == CMD_RD) || (cmd == CMD_WR)) begin
                    if (in_burst) begin
                        trk_d.st  = BK_OPEN;
                        trk_d.cnt = '0;
                    end else if ((trk_q.st == BK_RD_AP) || (trk_q.st == BK_WR_AP)) begin
                        trk_d = arm(BK_CLOSING, BK_IDLE, n_rp);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q.st  <= BK_IDLE;
            trk_q.cnt <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign state_o = trk_q.st;

    // R2: an opening bank always has time left to run
    a_r2_opening_timed: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.st == BK_OPENING) |-> (trk_q.cnt != '0));

    // R2: an accepted activate leaves the idle state
    a_r2_act_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (run && accept && hit && (cmd == CMD_ACT)) |=>
        ((trk_q.st == BK_OPENING) || (trk_q.st == BK_OPEN)));

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
    import sdram_guard_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int CNT_W     = 4,
    parameter int XSR_W     = 8,
    parameter int BA_W      = $clog2(NUM_BANKS),
    parameter int ERR_W     = 3 + BA_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BA_W-1:0]        ba,
    input  logic                   a10,
    input  logic [CNT_W-1:0]       cfg_trcd,
    input  logic [CNT_W-1:0]       cfg_trp,
    input  logic [CNT_W-1:0]       cfg_burst,
    input  logic [XSR_W-1:0]       cfg_txsr,
    output logic                   legal_o,
    output logic [ERR_W-1:0]       err_code_o,
    output logic [3*NUM_BANKS-1:0] bank_state_o
);

    typedef struct packed {
        logic             cke;
        logic [XSR_W-1:0] hold;
        logic             legal;
        logic [ERR_W-1:0] err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    cmd_e                 cmd;
    bank_e                st   [NUM_BANKS];
    logic [NUM_BANKS-1:0] ok_vec;
    logic [NUM_BANKS-1:0] burst_vec;
    logic                 en, violation, accept;
    logic [2:0]           code;

    sdram_cmd_decode u_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd_o (cmd)
    );

    assign en = cke && ctl_q.cke && (ctl_q.hold == '0);

    always_comb begin
        case (cmd)
            CMD_ACT, CMD_RD, CMD_WR: violation = !ok_vec[ba];
            CMD_PRE:                 violation = a10 ? !(&ok_vec) : !ok_vec[ba];
            default:                 violation = 1'b0;
        endcase
        code   = ((cmd == CMD_PRE) && a10) ? CODE_PRE_ALL : 3'(cmd);
        accept = en && !violation;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
            logic hit;
            assign hit = (ba == BA_W'(gi)) || ((cmd == CMD_PRE) && a10);

            sdram_bank_track #(.CNT_W(CNT_W)) u_track (
                .clk     (clk),
                .rst_n   (rst_n),
                .run     (cke),
                .accept  (accept),
                .hit     (hit),
                .cmd     (cmd),
                .a10     (a10),
                .trcd    (cfg_trcd),
                .trp     (cfg_trp),
                .burst   (cfg_burst),
                .state_o (st[gi]),
                .ok_o    (ok_vec[gi])
            );

            assign bank_state_o[3*gi +: 3] = st[gi];
            assign burst_vec[gi] = (st[gi] == BK_RD) || (st[gi] == BK_WR) ||
                                   (st[gi] == BK_RD_AP) || (st[gi] == BK_WR_AP);
        end
    endgenerate

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.cke = cke;
        if (cke && !ctl_q.cke) begin
            ctl_d.hold = cfg_txsr;
        end else if (cke && (ctl_q.hold != '0)) begin
            ctl_d.hold = ctl_q.hold - XSR_W'(1);
        end
        ctl_d.legal = !(en && violation);
        if (en && violation) begin
            ctl_d.err = {code, ba};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.cke   <= 1'b0;
            ctl_q.hold  <= '0;
            ctl_q.legal <= 1'b1;
            ctl_q.err   <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign legal_o    = ctl_q.legal;
    assign err_code_o = ctl_q.err;

    // R8: the data bus belongs to at most one bank
    a_r8_single_burst: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(burst_vec) <= 1);

    // R10: bank states hold across a cycle with the clock enable low
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> $stable(bank_state_o));

    // R9: a reported violation always carries a command code
    a_r9_code_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        !legal_o |-> (err_code_o[ERR_W-1:BA_W] != 3'd0));

    // R10: nothing is flagged while the clock enable is low
    a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> legal_o);

endmodule

// File: tb/sdram_cmd_guard_tb.sv
`timescale 1ns/1ps
module sdram_cmd_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic        a10 = 1'b0;
    logic [3:0]  cfg_trcd = 4'd2, cfg_trp = 4'd2, cfg_burst = 4'd2;
    logic [7:0]  cfg_txsr = 8'd0;
    logic        legal_o;
    logic [4:0]  err_code_o;
    logic [11:0] bank_state_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sdram_cmd_guard dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cke          (cke),
        .cs_n         (cs_n),
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .we_n         (we_n),
        .ba           (ba),
        .a10          (a10),
        .cfg_trcd     (cfg_trcd),
        .cfg_trp      (cfg_trp),
        .cfg_burst    (cfg_burst),
        .cfg_txsr     (cfg_txsr),
        .legal_o      (legal_o),
        .err_code_o   (err_code_o),
        .bank_state_o (bank_state_o)
    );

    // command codes: 0 nop, 1 act, 2 read, 3 write, 4 precharge, 5 inhibit, 6 refresh
    task automatic set_cmd(input logic [2:0] c, input logic [1:0] b, input logic a);
        ba  = b;
        a10 = a;
        case (c)
            3'd1:    {cs_n, ras_n, cas_n, we_n} = 4'b0011;
            3'd2:    {cs_n, ras_n, cas_n, we_n} = 4'b0101;
            3'd3:    {cs_n, ras_n, cas_n, we_n} = 4'b0100;
            3'd4:    {cs_n, ras_n, cas_n, we_n} = 4'b0010;
            3'd5:    {cs_n, ras_n, cas_n, we_n} = 4'b1000;
            3'd6:    {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
        endcase
    endtask

    task automatic step(input logic [2:0] c, input logic [1:0] b, input logic a);
        set_cmd(c, b, a);
        @(posedge clk);
        #1;
    endtask

    task automatic check(input int r, input logic el, input logic [4:0] ee, input logic [11:0] es);
        checks++;
        if (legal_o !== el || err_code_o !== ee || bank_state_o !== es) begin
            errors++;
            $display("FAIL R%0d: legal=%0b err=%0d state=%03h, expected legal=%0b err=%0d state=%03h",
                     r, legal_o, err_code_o, bank_state_o, el, ee, es);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cke   = 1'b1;
        set_cmd(3'd0, 2'd0, 1'b0);
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    // {req[3:0], cmd[2:0], ba[1:0], a10, legal, err[4:0], state {b3,b2,b1,b0}}
    localparam int NV = 28;
    localparam logic [27:0] TBL [NV] = '{
        {4'd2,  3'd1, 2'd0, 1'b0, 1'b1, 5'd0,  {3'd0, 3'd0, 3'd0, 3'd1}}, // R2 act b0
        {4'd3,  3'd2, 2'd0, 1'b0, 1'b0, 5'd8,  {3'd0, 3'd0, 3'd0, 3'd2}}, // R3 read while opening
        {4'd4,  3'd2, 2'd0, 1'b0, 1'b1, 5'd8,  {3'd0, 3'd0, 3'd0, 3'd3}}, // R4 read starts
        {4'd4,  3'd0, 2'd0, 1'b0, 1'b1, 5'd8,  {3'd0, 3'd0, 3'd0, 3'd2}}, // R4 burst ends
        {4'd2,  3'd1, 2'd1, 1'b0, 1'b1, 5'd8,  {3'd0, 3'd0, 3'd1, 3'd2}}, // R2 act b1
        {4'd1,  3'd0, 2'd0, 1'b0, 1'b1, 5'd8,  {3'd0, 3'd0, 3'd2, 3'd2}}, // R1 nop
        {4'd4,  3'd2, 2'd0, 1'b0, 1'b1, 5'd8,  {3'd0, 3'd0, 3'd2, 3'd3}}, // R4 read b0
        {4'd8,  3'd2, 2'd1, 1'b0, 1'b1, 5'd8,  {3'd0, 3'd0, 3'd3, 3'd2}}, // R8 read b1 cuts b0
        {4'd5,  3'd3, 2'd1, 1'b1, 1'b1, 5'd8,  {3'd0, 3'd0, 3'd6, 3'd2}}, // R5 write ap b1
        {4'd8,  3'd2, 2'd0, 1'b0, 1'b1, 5'd8,  {3'd0, 3'd0, 3'd7, 3'd3}}, // R8 read b0 closes b1
        {4'd6,  3'd0, 2'd0, 1'b0, 1'b1, 5'd8,  {3'd0, 3'd0, 3'd0, 3'd2}}, // R6 b1 idle
        {4'd2,  3'd1, 2'd0, 1'b0, 1'b0, 5'd4,  {3'd0, 3'd0, 3'd0, 3'd2}}, // R2 act to open bank
        {4'd6,  3'd4, 2'd0, 1'b0, 1'b1, 5'd4,  {3'd0, 3'd0, 3'd0, 3'd7}}, // R6 precharge b0
        {4'd3,  3'd3, 2'd0, 1'b0, 1'b0, 5'd12, {3'd0, 3'd0, 3'd0, 3'd0}}, // R3 write to closing
        {4'd2,  3'd1, 2'd2, 1'b0, 1'b1, 5'd12, {3'd0, 3'd1, 3'd0, 3'd0}}, // R2 act b2
        {4'd7,  3'd4, 2'd3, 1'b1, 1'b0, 5'd23, {3'd0, 3'd2, 3'd0, 3'd0}}, // R7 all-bank vs opening
        {4'd2,  3'd1, 2'd3, 1'b0, 1'b1, 5'd23, {3'd1, 3'd2, 3'd0, 3'd0}}, // R2 act b3
        {4'd4,  3'd3, 2'd2, 1'b0, 1'b1, 5'd23, {3'd2, 3'd4, 3'd0, 3'd0}}, // R4 write b2
        {4'd7,  3'd4, 2'd0, 1'b1, 1'b1, 5'd23, {3'd7, 3'd7, 3'd0, 3'd0}}, // R7 all-bank closes
        {4'd7,  3'd0, 2'd0, 1'b0, 1'b1, 5'd23, {3'd0, 3'd0, 3'd0, 3'd0}}, // R7 all idle
        {4'd2,  3'd1, 2'd1, 1'b0, 1'b1, 5'd23, {3'd0, 3'd0, 3'd1, 3'd0}}, // R2 act b1
        {4'd2,  3'd0, 2'd0, 1'b0, 1'b1, 5'd23, {3'd0, 3'd0, 3'd2, 3'd0}}, // R2 open
        {4'd5,  3'd2, 2'd1, 1'b1, 1'b1, 5'd23, {3'd0, 3'd0, 3'd5, 3'd0}}, // R5 read ap b1
        {4'd5,  3'd2, 2'd1, 1'b0, 1'b0, 5'd9,  {3'd0, 3'd0, 3'd5, 3'd0}}, // R5 read to ap bank
        {4'd6,  3'd4, 2'd1, 1'b0, 1'b0, 5'd17, {3'd0, 3'd0, 3'd5, 3'd0}}, // R6 precharge ap bank
        {4'd5,  3'd0, 2'd0, 1'b0, 1'b1, 5'd17, {3'd0, 3'd0, 3'd0, 3'd0}}, // R5 ap self-expiry
        {4'd1,  3'd6, 2'd0, 1'b0, 1'b1, 5'd17, {3'd0, 3'd0, 3'd0, 3'd0}}, // R1 refresh ignored
        {4'd1,  3'd5, 2'd0, 1'b0, 1'b1, 5'd17, {3'd0, 3'd0, 3'd0, 3'd0}}  // R1 inhibit
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R11 reset state
        do_reset();
        check(11, 1'b1, 5'd0, 12'h000);
        step(3'd0, 2'd0, 1'b0);
        check(11, 1'b1, 5'd0, 12'h000);

        for (int i = 0; i < NV; i++) begin
            step(TBL[i][23:21], TBL[i][20:19], TBL[i][18]);
            check(int'(TBL[i][27:24]), TBL[i][17], TBL[i][16:12], TBL[i][11:0]);
        end

        // R11 reset clears the latched code
        do_reset();
        check(11, 1'b1, 5'd0, 12'h000);

        // one-cycle intervals skip the timed states
        cfg_trcd = 4'd1; cfg_trp = 4'd1; cfg_burst = 4'd1;
        step(3'd0, 2'd0, 1'b0);
        step(3'd1, 2'd0, 1'b0);
        check(2, 1'b1, 5'd0, 12'h002);          // R2 open at once
        step(3'd2, 2'd0, 1'b0);
        check(4, 1'b1, 5'd0, 12'h002);          // R4 burst of one
        step(3'd2, 2'd0, 1'b1);
        check(5, 1'b1, 5'd0, 12'h005);          // R5 ap for two cycles
        step(3'd0, 2'd0, 1'b0);
        check(5, 1'b1, 5'd0, 12'h000);
        step(3'd1, 2'd0, 1'b0);
        step(3'd4, 2'd0, 1'b0);
        check(6, 1'b1, 5'd0, 12'h000);          // R6 one-cycle precharge

        // clock-enable gating and wake-up window
        cfg_trcd = 4'd2; cfg_trp = 4'd2; cfg_burst = 4'd2;
        do_reset();
        cfg_txsr = 8'd0;
        step(3'd0, 2'd0, 1'b0);
        cfg_trcd = 4'd3;
        cfg_txsr = 8'd2;
        step(3'd1, 2'd0, 1'b0);
        check(2, 1'b1, 5'd0, 12'h001);
        cke = 1'b0;
        step(3'd1, 2'd1, 1'b0);
        check(10, 1'b1, 5'd0, 12'h001);         // R10 frozen, act ignored
        step(3'd1, 2'd0, 1'b0);
        check(10, 1'b1, 5'd0, 12'h001);         // R10 illegal act not flagged
        cke = 1'b1;
        step(3'd1, 2'd0, 1'b0);
        check(10, 1'b1, 5'd0, 12'h001);         // R10 first cycle unchecked
        step(3'd1, 2'd2, 1'b0);
        check(10, 1'b1, 5'd0, 12'h002);         // R10 window: act b2 ignored
        step(3'd1, 2'd0, 1'b0);
        check(10, 1'b1, 5'd0, 12'h002);         // R10 window still open
        step(3'd1, 2'd0, 1'b0);
        check(9, 1'b0, 5'd4, 12'h002);          // R9 checking resumed

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule